// File: doc/BRIEF.md
# Rotating Multi-Unit Tree Search Engine

This block finds a key in a sorted table of N entries spread over M small on-chip memories. Entry k (numbered 1 to N) sits in memory unit (k mod M), where a result of zero selects unit M. Inside that unit it sits at local index (k−1) div M. One lookup descends an (M−1)-ary tree. On every level, M−1 of the units each read one entry in parallel while the remaining unit sits the level out. The entries read narrow the search window for the next level.

Which unit serves which branch of the tree changes from level to level. Every unit derives its branch number from the window's upper bound modulo M. On odd levels the branch number rises with the unit number. On even levels it falls. The search stops early when a probed key equals the target. Otherwise it stops after the last level. It then reports hit or miss. For a hit it reports the location of the matching entry. For a miss it reports the location where the target would have to be inserted.

The table is loaded through a one-entry-per-cycle write port. A lookup is launched with a one-cycle start pulse.

Top module: `tsrch_top`

## Requirements
- R1: A write with location k (1 ≤ k ≤ N) stores the key in unit (k mod M, 0 meaning M) at index (k−1) div M. Every one of the N locations can later be found by a lookup.
- R2: When the target equals a stored key (keys strictly increasing), `done` is returned with `hit`=1 and `loc` equal to that key's location.
- R3: When no stored key equals the target, `done` is returned with `hit`=0 and `loc` equal to the first location whose key exceeds the target. If the target exceeds every key, `loc` is N+1.
- R4: Each tree level takes exactly 3 cycles. `done` rises 3·L cycles after the cycle in which `start` is sampled, where 1 ≤ L ≤ log base (M−1) of N (3 for the defaults).
- R5: A target equal to a key probed on level 1 (locations N/(M−1), 2N/(M−1), …, N) completes after 3 cycles. A target above every key also completes after 3 cycles.
- R6: On every level exactly one unit idles, and every probed location is held by the unit that reads it. A target at location 38 (N=64, M=5) is found on the third level, 9 cycles after start.
- R7: `done` is a one-cycle pulse with `busy` low in that cycle. `busy` is high from the cycle after `start` is sampled until `done`. `hit` and `loc` hold their values until the next lookup finishes.
- R8: A `start` pulse while `busy` is high is ignored. The running lookup returns the result for its own target, and no second lookup begins.
- R9: After reset, `busy`, `done`, `hit` and `loc` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Store `wr_key` at location `wr_loc` |
| wr_loc | input | $clog2(N+2) | Location to write, 1..N |
| wr_key | input | KEY_W | Key to store |
| start | input | 1 | Launch a lookup of `target` (taken only when idle) |
| target | input | KEY_W | Key to search for |
| busy | output | 1 | A lookup is in progress |
| done | output | 1 | One-cycle pulse: result valid |
| hit | output | 1 | Target found |
| loc | output | $clog2(N+2) | Location of the match, or the insertion location on a miss |

## Verification
The bench builds the block with its defaults, N=64, M=5 and 16-bit keys. This is the configuration in which the three-level descent and the alternating rotation of the five units all occur. Two strictly increasing tables are loaded. For each table, every target from zero to just beyond the largest key is swept. This covers a hit at every location, a miss in every gap, the miss below the first key and the miss above the last key. Each result and latency is compared with a linear scan done in the bench. Dedicated cases cover the level-1 early stops, the worked location-38 case, a start pulse during a lookup, and the state after reset.

// File: rtl/tsrch_pkg.sv
package tsrch_pkg;

  // Number of (d)-ary levels needed to cover n entries.
  function automatic int tree_height(input int n, input int d);
    int h;
    int span;
    h = 0;
    span = 1;
    while (span < n) begin
      span = span * d;
      h = h + 1;
    end
    return h;
  endfunction

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_SETUP = 2'd1,
    S_READ  = 2'd2,
    S_CMP   = 2'd3
  } tsrch_state_e;

endpackage

// File: rtl/tsrch_unit.sv
module tsrch_unit #(
  parameter int N       = 64,
  parameter int M       = 5,
  parameter int KEY_W   = 16,
  parameter int LOC_W   = 7,
  parameter int PATH_W  = 3,
  parameter int UNIT_ID = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOC_W-1:0]  ub,
  input  logic [LOC_W-1:0]  bs,
  input  logic              odd_lvl,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [LOC_W-1:0]  wr_loc,
  input  logic [KEY_W-1:0]  wr_key,
  output logic [PATH_W-1:0] path_c,
  output logic [LOC_W-1:0]  loc_c,
  output logic [PATH_W-1:0] path_r,
  output logic [LOC_W-1:0]  loc_r,
  output logic [KEY_W-1:0]  key_r
);
  localparam int          D     = M - 1;
  localparam int          DEPTH = (N + M - 1) / M;
  localparam int          IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [31:0] ID32  = 32'(UNIT_ID);
  localparam logic [31:0] D32   = 32'(D);
  localparam logic [31:0] M32   = 32'(M);
  localparam logic [31:0] N32   = 32'(N);

  logic [KEY_W-1:0] mem [DEPTH];

  logic [31:0] ub32, bs32, j32, t32, p32, probe32, ridx32, wloc32, widx32;
  logic        wsel;

  // Branch assignment for this unit on the current level.
  always_comb begin
    ub32 = 32'(ub);
    bs32 = 32'(bs);
    j32  = ub32 % M32;
    t32  = 32'd0;
    if (odd_lvl) begin
      if (ID32 <= j32) p32 = ID32 + D32 - j32;
      else             p32 = ID32 - j32 - 32'd1;
    end else begin
      t32 = (ID32 + M32 - j32) % M32;
      p32 = D32 - t32;
    end
    if (p32 == 32'd0) begin
      probe32 = 32'd0;
      ridx32  = 32'd0;
    end else begin
      probe32 = ub32 - bs32 * (D32 - p32);
      ridx32  = (probe32 - 32'd1) / M32;
    end
  end

  assign path_c = PATH_W'(p32);
  assign loc_c  = LOC_W'(probe32);

  // Write decode: this unit owns locations congruent to its number.
  always_comb begin
    wloc32 = 32'(wr_loc);
    widx32 = (wloc32 == 32'd0) ? 32'd0 : (wloc32 - 32'd1) / M32;
    wsel   = wr_en && (wloc32 != 32'd0) && (wloc32 <= N32) &&
             ((wloc32 % M32) == (ID32 % M32));
  end

  always_ff @(posedge clk) begin
    if (wsel) mem[IDX_W'(widx32)] <= wr_key;
  end

  always_ff @(posedge clk) begin
    if (rd_en) key_r <= mem[IDX_W'(ridx32)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      path_r <= '0;
      loc_r  <= '0;
    end else if (rd_en) begin
      path_r <= path_c;
      loc_r  <= loc_c;
    end
  end

endmodule

// File: rtl/tsrch_pick.sv
module tsrch_pick #(
  parameter int M      = 5,
  parameter int KEY_W  = 16,
  parameter int LOC_W  = 7,
  parameter int PATH_W = 3
) (
  input  logic [KEY_W-1:0]          target,
  input  logic [M-1:0][PATH_W-1:0]  upath,
  input  logic [M-1:0][KEY_W-1:0]   ukey,
  input  logic [M-1:0][LOC_W-1:0]   uloc,
  output logic [PATH_W-1:0]         sel_path,
  output logic [LOC_W-1:0]          sel_loc,
  output logic                      sel_hit,
  output logic                      sel_none
);
  localparam int D = M - 1;

  logic [D:1][KEY_W-1:0] key_at;
  logic [D:1][LOC_W-1:0] loc_at;
  logic                  found;

  // Reorder unit results by branch number.
  always_comb begin
    key_at = '0;
    loc_at = '0;
    for (int u = 0; u < M; u++) begin
      for (int p = 1; p <= D; p++) begin
        if (upath[u] == PATH_W'(p)) begin
          key_at[p] = ukey[u];
          loc_at[p] = uloc[u];
        end
      end
    end
  end

  // Lowest branch whose key reaches the target wins.
  always_comb begin
    found    = 1'b0;
    sel_path = '0;
    sel_loc  = '0;
    sel_hit  = 1'b0;
    for (int p = 1; p <= D; p++) begin
      if (!found && (key_at[p] >= target)) begin
        found    = 1'b1;
        sel_path = PATH_W'(p);
        sel_loc  = loc_at[p];
        sel_hit  = (key_at[p] == target);
      end
    end
    sel_none = !found;
  end

endmodule

// File: rtl/tsrch_ctrl.sv
module tsrch_ctrl
  import tsrch_pkg::*;
#(
  parameter int N      = 64,
  parameter int M      = 5,
  parameter int KEY_W  = 16,
  parameter int LOC_W  = 7,
  parameter int PATH_W = 3,
  parameter int HEIGHT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [KEY_W-1:0]  target,
  input  logic [PATH_W-1:0] sel_path,
  input  logic [LOC_W-1:0]  sel_loc,
  input  logic              sel_hit,
  input  logic              sel_none,
  output logic [KEY_W-1:0]  tgt,
  output logic [LOC_W-1:0]  ub,
  output logic [LOC_W-1:0]  bs,
  output logic              odd_lvl,
  output logic              rd_en,
  output logic              busy,
  output logic              done,
  output logic              hit,
  output logic [LOC_W-1:0]  loc
);
  localparam int LVL_W = $clog2(HEIGHT + 2);
  localparam logic [31:0] D32 = 32'(M - 1);

  tsrch_state_e      st_q, st_n;
  logic [LOC_W-1:0]  ub_q, ub_n, bs_q, bs_n, loc_q, loc_n;
  logic [PATH_W-1:0] path_q, path_n;
  logic [LVL_W-1:0]  lvl_q, lvl_n;
  logic [KEY_W-1:0]  tgt_q, tgt_n;
  logic              hit_q, hit_n, done_q, done_n;

  always_comb begin
    st_n   = st_q;
    ub_n   = ub_q;
    bs_n   = bs_q;
    path_n = path_q;
    lvl_n  = lvl_q;
    tgt_n  = tgt_q;
    hit_n  = hit_q;
    loc_n  = loc_q;
    done_n = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          tgt_n  = target;
          ub_n   = LOC_W'(N);
          bs_n   = LOC_W'(N);
          path_n = PATH_W'(M - 1);
          lvl_n  = LVL_W'(1);
          st_n   = S_SETUP;
        end
      end
      S_SETUP: begin
        ub_n = LOC_W'(32'(ub_q) - 32'(bs_q) * (D32 - 32'(path_q)));
        bs_n = LOC_W'(32'(bs_q) / D32);
        st_n = S_READ;
      end
      S_READ: st_n = S_CMP;
      S_CMP: begin
        if (sel_none) begin
          done_n = 1'b1;
          hit_n  = 1'b0;
          loc_n  = ub_q + LOC_W'(1);
          st_n   = S_IDLE;
        end else if (sel_hit || (lvl_q == LVL_W'(HEIGHT))) begin
          done_n = 1'b1;
          hit_n  = sel_hit;
          loc_n  = sel_loc;
          st_n   = S_IDLE;
        end else begin
          path_n = sel_path;
          lvl_n  = lvl_q + LVL_W'(1);
          st_n   = S_SETUP;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ub_q   <= '0;
      bs_q   <= '0;
      path_q <= '0;
      lvl_q  <= '0;
      tgt_q  <= '0;
      hit_q  <= 1'b0;
      loc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      ub_q   <= ub_n;
      bs_q   <= bs_n;
      path_q <= path_n;
      lvl_q  <= lvl_n;
      tgt_q  <= tgt_n;
      hit_q  <= hit_n;
      loc_q  <= loc_n;
      done_q <= done_n;
    end
  end

  assign tgt     = tgt_q;
  assign ub      = ub_q;
  assign bs      = bs_q;
  assign odd_lvl = lvl_q[0];
  assign rd_en   = (st_q == S_READ);
  assign busy    = (st_q != S_IDLE);
  assign done    = done_q;
  assign hit     = hit_q;
  assign loc     = loc_q;

endmodule

// File: rtl/tsrch_top.sv
module tsrch_top
  import tsrch_pkg::*;
#(
  parameter int N     = 64,
  parameter int M     = 5,
  parameter int KEY_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(N+2)-1:0]   wr_loc,
  input  logic [KEY_W-1:0]         wr_key,
  input  logic                     start,
  input  logic [KEY_W-1:0]         target,
  output logic                     busy,
  output logic                     done,
  output logic                     hit,
  output logic [$clog2(N+2)-1:0]   loc
);
  localparam int D      = M - 1;
  localparam int HEIGHT = tree_height(N, D);
  localparam int LOC_W  = $clog2(N + 2);
  localparam int PATH_W = $clog2(M);

  logic [1:0] rst_sync;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  logic [KEY_W-1:0]         tgt;
  logic [LOC_W-1:0]         ub, bs;
  logic                     odd_lvl, rd_en;
  logic [M-1:0][PATH_W-1:0] upath_c, upath_r;
  logic [M-1:0][LOC_W-1:0]  uloc_c, uloc_r;
  logic [M-1:0][KEY_W-1:0]  ukey_r;
  logic [PATH_W-1:0]        sel_path;
  logic [LOC_W-1:0]         sel_loc;
  logic                     sel_hit, sel_none;

  for (genvar g = 0; g < M; g++) begin : g_unit
    tsrch_unit #(
      .N(N), .M(M), .KEY_W(KEY_W), .LOC_W(LOC_W), .PATH_W(PATH_W),
      .UNIT_ID(g + 1)
    ) u_unit (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .ub     (ub),
      .bs     (bs),
      .odd_lvl(odd_lvl),
      .rd_en  (rd_en),
      .wr_en  (wr_en),
      .wr_loc (wr_loc),
      .wr_key (wr_key),
      .path_c (upath_c[g]),
      .loc_c  (uloc_c[g]),
      .path_r (upath_r[g]),
      .loc_r  (uloc_r[g]),
      .key_r  (ukey_r[g])
    );
  end

  tsrch_pick #(
    .M(M), .KEY_W(KEY_W), .LOC_W(LOC_W), .PATH_W(PATH_W)
  ) u_pick (
    .target  (tgt),
    .upath   (upath_r),
    .ukey    (ukey_r),
    .uloc    (uloc_r),
    .sel_path(sel_path),
    .sel_loc (sel_loc),
    .sel_hit (sel_hit),
    .sel_none(sel_none)
  );

  tsrch_ctrl #(
    .N(N), .M(M), .KEY_W(KEY_W), .LOC_W(LOC_W), .PATH_W(PATH_W),
    .HEIGHT(HEIGHT)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .target  (target),
    .sel_path(sel_path),
    .sel_loc (sel_loc),
    .sel_hit (sel_hit),
    .sel_none(sel_none),
    .tgt     (tgt),
    .ub      (ub),
    .bs      (bs),
    .odd_lvl (odd_lvl),
    .rd_en   (rd_en),
    .busy    (busy),
    .done    (done),
    .hit     (hit),
    .loc     (loc)
  );

endmodule

// File: rtl/tsrch_chk.sv
module tsrch_chk #(
  parameter int N      = 64,
  parameter int M      = 5,
  parameter int LOC_W  = 7,
  parameter int PATH_W = 3,
  parameter int HEIGHT = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busy,
  input logic                     done,
  input logic                     hit,
  input logic [LOC_W-1:0]         loc,
  input logic                     rd_en,
  input logic [M-1:0][PATH_W-1:0] upath_c,
  input logic [M-1:0][LOC_W-1:0]  uloc_c
);
  logic [M-1:0] idle;
  logic [7:0]   lat_q;

  always_comb begin
    for (int u = 0; u < M; u++) idle[u] = (upath_c[u] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lat_q <= '0;
    else if (busy) lat_q <= lat_q + 8'd1;
    else           lat_q <= '0;
  end

  p_one_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ($countones(idle) == 1));

  for (genvar g = 0; g < M; g++) begin : g_own
    p_owner_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !idle[g]) |->
        ((32'(uloc_c[g]) % 32'(M)) == (32'(g + 1) % 32'(M))));
    p_probe_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !idle[g]) |->
        ((uloc_c[g] >= LOC_W'(1)) && (uloc_c[g] <= LOC_W'(N))));
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(loc) && $stable(hit)));

  p_hit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> ((loc >= LOC_W'(1)) && (loc <= LOC_W'(N))));

  p_miss_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hit) |-> ((loc >= LOC_W'(1)) && (loc <= LOC_W'(N + 1))));

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(lat_q) < 32'(3 * HEIGHT)));

endmodule

bind tsrch_top tsrch_chk #(
  .N(N), .M(M), .LOC_W(LOC_W), .PATH_W(PATH_W), .HEIGHT(HEIGHT)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .busy   (busy),
  .done   (done),
  .hit    (hit),
  .loc    (loc),
  .rd_en  (rd_en),
  .upath_c(upath_c),
  .uloc_c (uloc_c)
);

// File: tb/sim_tsrch_top.sv
`timescale 1ns/1ps
module sim_tsrch_top;
  localparam int N     = 64;
  localparam int M     = 5;
  localparam int KEY_W = 16;
  localparam int LOC_W = $clog2(N + 2);

  logic             clk, rst_n, wr_en, start;
  logic [LOC_W-1:0] wr_loc, loc;
  logic [KEY_W-1:0] wr_key, target;
  logic             busy, done, hit;

  int nchk;
  int nerr;
  int keys [1:N];

  tsrch_top #(.N(N), .M(M), .KEY_W(KEY_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_loc(wr_loc),
    .wr_key(wr_key), .start(start), .target(target),
    .busy(busy), .done(done), .hit(hit), .loc(loc)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int key_of(input int pat, input int k);
    if (pat == 0) return 3 * k + 1;
    return (k * (k + 1)) / 2;
  endfunction

  task automatic load(input int pat);
    for (int k = 1; k <= N; k++) begin
      keys[k] = key_of(pat, k);
      @(negedge clk);
      wr_en  = 1'b1;
      wr_loc = LOC_W'(k);
      wr_key = KEY_W'(keys[k]);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Returns the cycle count from start sampling to done.
  task automatic run(input int t, output int lat);
    @(negedge clk);
    start  = 1'b1;
    target = KEY_W'(t);
    @(negedge clk);
    start = 1'b0;
    lat   = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic expect_of(input int t, output int ehit, output int eloc);
    ehit = 0;
    eloc = N + 1;
    for (int k = N; k >= 1; k--) begin
      if (keys[k] >= t) begin
        eloc = k;
        ehit = (keys[k] == t) ? 1 : 0;
      end
    end
  endtask

  task automatic sweep(input int tmax);
    int lat, ehit, eloc;
    for (int t = 0; t <= tmax; t++) begin
      run(t, lat);
      expect_of(t, ehit, eloc);
      if (ehit == 1) begin
        chk("R1 R2 hit flag", int'(hit), 1);
        chk("R1 R2 hit location", int'(loc), eloc);
      end else begin
        chk("R3 miss flag", int'(hit), 0);
        chk("R3 insertion location", int'(loc), eloc);
      end
      chk("R4 latency multiple of 3 within height", lat,
          ((lat % 3 == 0) && (lat >= 3) && (lat <= 9)) ? lat : 9);
      chk("R7 busy low with done", int'(busy), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int lat;
    nchk   = 0;
    nerr   = 0;
    rst_n  = 1'b0;
    wr_en  = 1'b0;
    wr_loc = '0;
    wr_key = '0;
    start  = 1'b0;
    target = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state
    chk("R9 busy after reset", int'(busy), 0);
    chk("R9 done after reset", int'(done), 0);
    chk("R9 hit after reset", int'(hit), 0);
    chk("R9 loc after reset", int'(loc), 0);

    load(0);

    // R5: level-1 probes stop at once
    for (int q = 1; q <= 4; q++) begin
      run(keys[16 * q], lat);
      chk("R5 early stop latency", lat, 3);
      chk("R5 early stop hit", int'(hit), 1);
      chk("R5 early stop location", int'(loc), 16 * q);
    end
    run(keys[N] + 5, lat);
    chk("R5 above all latency", lat, 3);
    chk("R5 above all location", int'(loc), N + 1);
    chk("R3 above all miss", int'(hit), 0);

    // R6: worked case at location 38
    run(keys[38], lat);
    chk("R6 location 38 latency", lat, 9);
    chk("R6 location 38 hit", int'(hit), 1);
    chk("R6 location 38 location", int'(loc), 38);

    // R7: done is a single-cycle pulse
    @(negedge clk);
    chk("R7 done pulse ends", int'(done), 0);

    // R8: start during a lookup is ignored
    @(negedge clk);
    start  = 1'b1;
    target = KEY_W'(keys[38]);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R7 busy during lookup", int'(busy), 1);
    start  = 1'b1;
    target = '0;
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk("R8 own target hit", int'(hit), 1);
    chk("R8 own target location", int'(loc), 38);
    chk("R8 latency unchanged", lat, 9);
    repeat (3) begin
      @(negedge clk);
      chk("R8 no second lookup", int'(busy), 0);
      chk("R7 result held", int'(loc), 38);
    end

    sweep(keys[N] + 3);
    load(1);
    sweep(keys[N] + 3);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule